// File: doc/BRIEF.md
# Comma-Aligning Word Deserializer with Antiphase Byte Clocks

This block recovers 10-bit parallel words from a serial bit stream that arrives one bit per bit-clock cycle. The receive source is one of two line inputs or, for self-test, the output of a companion transmit serializer that is built into the block. The receiver keeps the ten most recent bits in a window, with the earliest received bit at window bit 0. When the window's low seven bits show either polarity of the 8B/10B comma, that window becomes an output word and fixes the word boundary. From then on one word is presented every ten bit clocks.

Each new word comes with a toggle on a pair of byte clocks. These run at half the word rate in antiphase, so successive words line up with a rising edge of clock A, then of clock B, then of A again. A one-cycle flag marks every presented word that holds a comma. Realignment can be switched off, in which case the boundary already found is kept whatever commas arrive later.

Top module: `rxw_deserializer`

## Requirements
- R1: While reset is held and right after it is released, the word output is zero, the comma flag is low, both byte clocks are low and the lock indication is low.
- R2: A window whose bits 0..6 (bit 0 received first) read 0,0,1,1,1,1,1 or 1,1,0,0,0,0,0 is a comma, that is word[6:0] equal to 7'h7C or 7'h03. With sync enabled, that window is presented as a word, lock goes high, and lock stays high until reset.
- R3: Once locked, exactly one word is presented every ten bit clocks. Word bit 0 is the first bit received on the wire.
- R4: With sync enabled, a comma found at a new bit offset restarts word framing so that the comma is the next word presented. Words completed before it are presented intact, and at most one word taken at the old boundary falls between them.
- R5: With sync disabled, commas at other offsets cause no realignment: words keep arriving every ten bit clocks at the previously locked boundary.
- R6: With loopback off, select 0 takes the receive stream from line A and select 1 takes it from line B. The other line has no effect.
- R7: The transmit serializer captures its parallel word once every ten bit clocks, in the cycle after the load strobe is high, and sends it bit 0 first. Loopback routes that stream into the receiver in place of both lines, so the receiver rebuilds the transmitted words.
- R8: Clock A rises with the first word after lock. Each further word toggles clock A, and clock B takes the previous value of A, so the words alternate between rising edges of A and B and the two clocks stay opposite.
- R9: The comma flag is high for exactly the cycle in which a word holding a comma is first presented, and low in every other cycle.
- R10: Before lock, no words are presented: the word output stays zero and both byte clocks stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_a_i | input | 1 | Serial line input A |
| line_b_i | input | 1 | Serial line input B |
| line_sel_i | input | 1 | Line select: 0 = A, 1 = B |
| loop_en_i | input | 1 | Loopback: receive the internal transmit stream |
| align_en_i | input | 1 | Enables comma realignment |
| tx_word_i | input | WORD_W | Parallel word for the transmit serializer |
| tx_load_o | output | 1 | High in the cycle before tx_word_i is captured |
| tx_bit_o | output | 1 | Transmit serial stream, bit 0 first |
| rx_word_o | output | WORD_W | Recovered aligned word |
| rx_mark_o | output | 1 | One-cycle flag: presented word holds a comma |
| rx_lock_o | output | 1 | Word boundary established |
| byte_clk_a_o | output | 1 | Half-rate byte clock A |
| byte_clk_b_o | output | 1 | Half-rate byte clock B, antiphase to A |

## Verification
Two events can land in the same cycle: a comma completing in the window, and the framing counter reaching the end of a word. When both fall on the same cycle they must give one word, one clock toggle and one flag. When the comma sits at a new offset, it must restart framing without losing the words before it. The same-cycle case is provoked by sending a second comma at the locked offset, in loopback and on line A. The offset case is provoked by slipping the stream by three bits ahead of a comma, with sync on and then with sync off. A scoreboard compares every presented word, its comma flag and the byte-clock phase with the queued transmit words. It uses a wildcard for the one old-boundary word, and in the sync-off run it uses precomputed words straddling the old boundary.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  localparam int unsigned SYM_W  = 10;
  localparam int unsigned MARK_W = 7;
  // window bits 0..6 read 0,0,1,1,1,1,1 (bit 0 first on the wire)
  localparam logic [MARK_W-1:0] MARK_POS = 7'b1111100;
  // window bits 0..6 read 1,1,0,0,0,0,0
  localparam logic [MARK_W-1:0] MARK_NEG = 7'b0000011;

  typedef enum logic [1:0] {
    SRC_LINE_A = 2'd0,
    SRC_LINE_B = 2'd1,
    SRC_LOOP   = 2'd2
  } src_e;
endpackage

// File: rtl/rxw_rst_sync.sv
module rxw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/rxw_tx_serializer.sv
module rxw_tx_serializer #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  output logic              load_o,
  output logic              bit_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              load;

  assign load = (cnt_q == LAST);

  always_comb begin
    if (load) begin
      sh_d  = word_i;
      cnt_d = '0;
    end else begin
      sh_d  = {1'b0, sh_q[WORD_W-1:1]};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LAST;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  assign load_o = load;
  assign bit_o  = sh_q[0];

  // R7: capture strobes are never back to back
  a_r7_load_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);
  // R7: counter stays inside one word period
  a_r7_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/rxw_rx_front.sv
module rxw_rx_front #(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned MARK_W = 7,
  parameter logic [MARK_W-1:0] MARK_POS = 7'b1111100,
  parameter logic [MARK_W-1:0] MARK_NEG = 7'b0000011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_i,
  output logic [WORD_W-1:0] win_o,
  output logic              hit_o
);
  localparam int unsigned NUM_MARKS = 2;

  logic [WORD_W-1:0] win_q, win_d;
  logic [MARK_W-1:0] marks [NUM_MARKS];
  logic [NUM_MARKS-1:0] match;

  assign marks[0] = MARK_POS;
  assign marks[1] = MARK_NEG;

  // newest bit enters at the top; bit 0 holds the earliest bit of the window
  assign win_d = {bit_i, win_q[WORD_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  for (genvar m = 0; m < NUM_MARKS; m++) begin : g_mark
    assign match[m] = (win_q[MARK_W-1:0] == marks[m]);
  end

  assign hit_o = |match;
  assign win_o = win_q;

  // R2: both polarities cannot match the same window
  a_r2_one_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/rxw_framer.sv
module rxw_framer #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] win_i,
  input  logic              hit_i,
  input  logic              align_en_i,
  output logic [WORD_W-1:0] word_o,
  output logic              mark_o,
  output logic              lock_o,
  output logic              clk_a_o,
  output logic              clk_b_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              lock_q, lock_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              mark_q, mark_d;
  logic              ca_q, ca_d, cb_q, cb_d;
  logic              realign, at_end, emit;

  assign realign = align_en_i & hit_i;
  assign at_end  = (cnt_q == LAST);
  assign emit    = realign | (lock_q & at_end);

  always_comb begin
    cnt_d  = (emit || at_end) ? '0 : cnt_q + 1'b1;
    lock_d = lock_q | realign;
    mark_d = emit & hit_i;
    word_d = word_q;
    ca_d   = ca_q;
    cb_d   = cb_q;
    if (emit) begin
      word_d = win_i;
      ca_d   = ~ca_q;
      cb_d   = ca_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
      word_q <= '0;
      mark_q <= 1'b0;
      ca_q   <= 1'b0;
      cb_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
      mark_q <= mark_d;
      if (emit) begin
        word_q <= word_d;
        ca_q   <= ca_d;
        cb_q   <= cb_d;
      end
    end
  end

  assign word_o  = word_q;
  assign mark_o  = mark_q;
  assign lock_o  = lock_q;
  assign clk_a_o = ca_q;
  assign clk_b_o = cb_q;

  // R8: once words flow the two byte clocks are opposite
  a_r8_antiphase: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> (ca_q != cb_q));
  // R10: nothing is presented before lock
  a_r10_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |-> (word_q == '0 && !ca_q && !cb_q));
  // R9: comma flag is a single-cycle pulse
  a_r9_mark_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mark_q |=> !mark_q);
  // R2: lock is sticky
  a_r2_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R9: a flagged word always comes with a byte clock toggle
  a_r9_mark_with_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    mark_q |-> (ca_q != $past(ca_q)));
endmodule

// File: rtl/rxw_deserializer.sv
module rxw_deserializer
  import rxw_pkg::*;
#(
  parameter int unsigned WORD_W = SYM_W,
  parameter int unsigned COMMA_W = MARK_W,
  parameter logic [COMMA_W-1:0] COMMA_POS = MARK_POS,
  parameter logic [COMMA_W-1:0] COMMA_NEG = MARK_NEG,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_a_i,
  input  logic              line_b_i,
  input  logic              line_sel_i,
  input  logic              loop_en_i,
  input  logic              align_en_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              tx_load_o,
  output logic              tx_bit_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_mark_o,
  output logic              rx_lock_o,
  output logic              byte_clk_a_o,
  output logic              byte_clk_b_o
);
  logic              srst_n;
  logic              tx_bit;
  src_e              src_sel;
  logic              rx_bit;
  logic [WORD_W-1:0] win;
  logic              hit;

  rxw_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  rxw_tx_serializer #(.WORD_W(WORD_W)) u_tx (
    .clk    (clk),
    .rst_n  (srst_n),
    .word_i (tx_word_i),
    .load_o (tx_load_o),
    .bit_o  (tx_bit)
  );

  always_comb begin
    if (loop_en_i)       src_sel = SRC_LOOP;
    else if (line_sel_i) src_sel = SRC_LINE_B;
    else                 src_sel = SRC_LINE_A;
  end

  always_comb begin
    case (src_sel)
      SRC_LOOP:   rx_bit = tx_bit;
      SRC_LINE_B: rx_bit = line_b_i;
      default:    rx_bit = line_a_i;
    endcase
  end

  rxw_rx_front #(
    .WORD_W   (WORD_W),
    .MARK_W   (COMMA_W),
    .MARK_POS (COMMA_POS),
    .MARK_NEG (COMMA_NEG)
  ) u_front (
    .clk   (clk),
    .rst_n (srst_n),
    .bit_i (rx_bit),
    .win_o (win),
    .hit_o (hit)
  );

  rxw_framer #(.WORD_W(WORD_W)) u_frm (
    .clk        (clk),
    .rst_n      (srst_n),
    .win_i      (win),
    .hit_i      (hit),
    .align_en_i (align_en_i),
    .word_o     (rx_word_o),
    .mark_o     (rx_mark_o),
    .lock_o     (rx_lock_o),
    .clk_a_o    (byte_clk_a_o),
    .clk_b_o    (byte_clk_b_o)
  );

  assign tx_bit_o = tx_bit;
endmodule

// File: tb/rxw_deserializer_tb.sv
module rxw_deserializer_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_a, line_b, line_sel, loop_en, align_en;
  logic [9:0] tx_word;
  logic       tx_load, tx_bit;
  logic [9:0] rx_word;
  logic       rx_mark, rx_lock, bclk_a, bclk_b;

  int   checks = 0;
  int   errors = 0;
  int   exp_q[$];
  logic mon_on = 1'b0;
  logic prev_a;
  int   cyc = 0;
  int   last_load = -1;
  logic done = 1'b0;

  always #10 clk = ~clk;

  rxw_deserializer u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_a_i     (line_a),
    .line_b_i     (line_b),
    .line_sel_i   (line_sel),
    .loop_en_i    (loop_en),
    .align_en_i   (align_en),
    .tx_word_i    (tx_word),
    .tx_load_o    (tx_load),
    .tx_bit_o     (tx_bit),
    .rx_word_o    (rx_word),
    .rx_mark_o    (rx_mark),
    .rx_lock_o    (rx_lock),
    .byte_clk_a_o (bclk_a),
    .byte_clk_b_o (bclk_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit is_comma(input int w);
    return (w[6:0] == 7'h7C) || (w[6:0] == 7'h03);
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (!mon_on) begin
      prev_a = 1'b0;
      last_load = -1;
    end else begin
      if (tx_load) begin
        if (last_load >= 0) chk(cyc - last_load == 10, "R7 load spacing", cyc - last_load, 10);
        last_load = cyc;
      end
      if (bclk_a != prev_a) begin
        chk(bclk_b == prev_a, "R8 clock B follows A", bclk_b, prev_a);
        chk(rx_lock == 1'b1, "R2 lock with word", rx_lock, 1);
        if (exp_q.size() > 0) begin
          int e;
          e = exp_q.pop_front();
          if (e >= 0) begin
            chk(rx_word == e[9:0], "R3 word", rx_word, e);
            chk(rx_mark == is_comma(e), "R9 comma flag", rx_mark, is_comma(e));
          end
        end
      end else begin
        chk(rx_mark == 1'b0, "R9 flag without word", rx_mark, 0);
      end
      prev_a = bclk_a;
    end
  end

  task automatic line_bit(input logic b);
    @(negedge clk);
    if (line_sel) begin
      line_b = b;
      line_a = ~b;
    end else begin
      line_a = b;
      line_b = ~b;
    end
  endtask

  task automatic line_word(input logic [9:0] w, input bit push);
    if (push) exp_q.push_back(int'(w));
    for (int i = 0; i < 10; i++) line_bit(w[i]);
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) line_bit(i[0]);
  endtask

  task automatic tx_send(input logic [9:0] w, input bit push);
    tx_word = w;
    forever begin
      @(negedge clk);
      if (tx_load) break;
    end
    if (push) exp_q.push_back(int'(w));
    @(negedge clk);
  endtask

  task automatic do_reset();
    mon_on = 1'b0;
    exp_q.delete();
    @(negedge clk);
    rst_n  = 1'b0;
    line_a = 1'b0;
    line_b = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state while reset held
    chk(rx_word == 10'd0 && !rx_mark && !rx_lock && !bclk_a && !bclk_b,
        "R1 state in reset", {rx_lock, bclk_a, bclk_b, rx_mark}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rx_word == 10'd0 && !rx_mark && !rx_lock && !bclk_a && !bclk_b,
        "R1 state after release", {rx_lock, bclk_a, bclk_b, rx_mark}, 0);
    mon_on = 1'b1;
  endtask

  task automatic drain(input string req);
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_sim();
    end
  end

  initial begin
    rst_n = 1'b0; line_a = 1'b0; line_b = 1'b0;
    line_sel = 1'b0; loop_en = 1'b0; align_en = 1'b1;
    tx_word = 10'h155;

    // Phase 1: line A, lock and steady words (R2 R3 R6 R9 R10)
    do_reset();
    line_bit(1'b1); line_bit(1'b0);
    idle_bits(6);
    chk(rx_lock == 1'b0 && rx_word == 10'd0 && !bclk_a, "R10 idle before comma", rx_word, 0);
    line_word(10'h17C, 1);
    line_word(10'h2AA, 1);
    line_word(10'h1B6, 1);
    line_word(10'h283, 1);   // comma at the locked offset: same-cycle case
    line_word(10'h155, 1);
    line_word(10'h2AA, 1);
    idle_bits(40);
    chk(rx_lock == 1'b1, "R2 lock held", rx_lock, 1);
    drain("R3 all line A words seen");

    // Phase 2: line B selected, line A carries the inverse (R6)
    line_sel = 1'b1;
    do_reset();
    line_bit(1'b1); line_bit(1'b0);
    line_word(10'h283, 1);
    line_word(10'h155, 1);
    line_word(10'h1B6, 1);
    line_word(10'h2AA, 1);
    idle_bits(40);
    drain("R6 all line B words seen");
    line_sel = 1'b0;

    // Phase 3: loopback of the transmit serializer, lines held low (R7)
    loop_en = 1'b1;
    do_reset();
    tx_send(10'h155, 0);
    tx_send(10'h17C, 1);
    tx_send(10'h2AA, 1);
    tx_send(10'h1B6, 1);
    tx_send(10'h283, 1);
    tx_send(10'h155, 1);
    tx_word = 10'h155;
    drain("R7 all loopback words seen");
    loop_en = 1'b0;

    // Phase 4: three-bit slip then comma with sync on (R4)
    do_reset();
    line_bit(1'b1); line_bit(1'b0);
    line_word(10'h17C, 1);
    line_word(10'h2AA, 1);
    line_word(10'h155, 1);
    exp_q.push_back(-1);     // one word taken at the old boundary
    line_bit(1'b1); line_bit(1'b0); line_bit(1'b1);
    line_word(10'h17C, 1);
    line_word(10'h1B6, 1);
    line_word(10'h155, 1);
    idle_bits(40);
    drain("R4 realigned words seen");

    // Phase 5: same slip with sync off keeps the old boundary (R5)
    do_reset();
    line_bit(1'b1); line_bit(1'b0);
    line_word(10'h17C, 1);
    line_word(10'h155, 1);
    line_word(10'h155, 1);
    align_en = 1'b0;
    exp_q.push_back(32'h3E5);
    exp_q.push_back(32'h152);
    exp_q.push_back(32'h2AD);
    line_bit(1'b1); line_bit(1'b0); line_bit(1'b1);
    line_word(10'h17C, 0);
    line_word(10'h2AA, 0);
    line_word(10'h155, 0);
    chk(rx_lock == 1'b1, "R5 lock kept with sync off", rx_lock, 1);
    idle_bits(20);
    drain("R5 old-boundary words seen");
    align_en = 1'b1;

    done = 1'b1;
    finish_sim();
  end
endmodule